// File: doc/BRIEF.md
# Element change detector and forwarder

This block keeps a table of `DEPTH` words of `WIDTH` bits (512 × 64 by default). It takes updates one element per cycle on a write port. A write port carries an index and a data word. On each write, one word-wide comparator checks the incoming word against the word already stored at that index. The block never compares the whole table in one cycle. When the two words differ, the new word is stored and a one-bit flag for that element is set. One flag covers the whole word, so the block tracks changes per element and not per bit. A write that matches the stored word does nothing.

An output stream carries only the flagged elements, as index/data pairs, with valid/ready signalling. The lowest flagged index is offered first. An element that changes several times before it is sent goes out once, with its latest value.

Back-pressure rules:
- The write port is never stalled. A write presented with `upd_valid` is taken on that clock edge.
- On the output side, `chg_valid` stays high while any flag is set, and drops only through accepts.
- The offered pair is always the current lowest flagged element with its current stored word. A write arriving while the output is stalled can therefore replace the offered pair with a lower index or a newer word.
- An element transfers on a clock edge where `chg_valid` and `chg_ready` are both high.

Top module: `chg_fwd_table`

## Requirements
- R1: After reset, every table entry reads as zero and no flag is set (`chg_valid` is 0). The first write of a nonzero word to any index counts as a change, and a first write of zero does not.
- R2: A write whose data differs from the stored word in at least one bit sets the flag of that index on the same clock edge. From the next cycle the element is offered on the output with the new word.
- R3: A write whose data equals the stored word leaves the flag and the stored word unchanged and causes no output traffic.
- R4: A write always leaves its data as the stored word of its index. An element changed several times before it is accepted is forwarded exactly once, carrying the last written word.
- R5: While any flag is set, `chg_idx` is the lowest index whose flag is set, and `chg_data` is that entry's stored word.
- R6: `chg_valid` is high exactly when at least one flag is set. It does not fall while `chg_ready` is low, so no change is lost under back-pressure.
- R7: Accepting an element clears its flag. If a differing write to the same index lands on the accepting edge, the flag stays set and the new word is forwarded later.
- R8: The write port accepts one write every cycle with no stall. It carries a 9-bit index (0 to 511) and a 64-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Write strobe, taken every cycle it is high |
| upd_idx | input | 9 | Element index of the write |
| upd_data | input | 64 | Word to write |
| chg_valid | output | 1 | A changed element is offered |
| chg_ready | input | 1 | Consumer takes the offered element |
| chg_idx | output | 9 | Index of the offered element |
| chg_data | output | 64 | Stored word of the offered element |

## Verification
The bound checker watches the flag map on every cycle:
- a differing write sets its flag, and an equal write with no accept leaves the map still;
- the offered index is the lowest set flag;
- an accepted flag clears unless the same index is rewritten with a new word on that edge;
- a stalled output keeps its valid high.

Some behaviour only the bench scenarios can show, because it depends on sequences of operations:
- that the stored words come back intact;
- that a repeatedly changed element goes out once with its final word;
- that several pending elements drain in ascending index order.

The bench's reference model compares index, data and valid on every cycle, over directed cases and a long run of mixed writes and back-pressure.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  localparam int unsigned CFW_DEPTH = 512;
  localparam int unsigned CFW_WIDTH = 64;
  localparam int unsigned CFW_IDXW  = $clog2(CFW_DEPTH);
endpackage

// File: rtl/cfw_lowest_first.sv
// Finds the lowest set bit of a request vector.
module cfw_lowest_first #(
  parameter int unsigned N    = 512,
  parameter int unsigned IDXW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [IDXW-1:0] sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    // scan downward so the lowest set bit is the last one assigned
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        sel = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/cfw_word_store.sv
// Word table with one compare read port and one forward read port.
module cfw_word_store #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WIDTH = 64,
  parameter int unsigned IDXW  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_differs,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] words [DEPTH];
  logic [WIDTH-1:0] cur_word;

  assign cur_word   = words[wr_idx];
  // a single word-wide comparator on the write path
  assign wr_differs = |(cur_word ^ wr_data);
  assign rd_data    = words[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) words[i] <= '0;
    end else if (wr_en && wr_differs) begin
      words[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/cfw_flag_map.sv
// One change flag per element; set by differing writes, cleared on accept.
module cfw_flag_map #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned IDXW  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDXW-1:0]  set_idx,
  input  logic             clr_en,
  input  logic [IDXW-1:0]  clr_idx,
  output logic [DEPTH-1:0] flags
);
  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == IDXW'(g));
    assign hit_clr = clr_en && (clr_idx == IDXW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       flags[g] <= 1'b0;
      else if (hit_set) flags[g] <= 1'b1;   // set wins over clear
      else if (hit_clr) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/chg_fwd_table.sv
module chg_fwd_table #(
  parameter int unsigned DEPTH = cfw_pkg::CFW_DEPTH,
  parameter int unsigned WIDTH = cfw_pkg::CFW_WIDTH,
  localparam int unsigned IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [IDXW-1:0]  upd_idx,
  input  logic [WIDTH-1:0] upd_data,
  output logic             chg_valid,
  input  logic             chg_ready,
  output logic [IDXW-1:0]  chg_idx,
  output logic [WIDTH-1:0] chg_data
);
  logic             wr_diff;
  logic [DEPTH-1:0] dirty;
  logic             take;

  assign take = chg_valid && chg_ready;

  cfw_word_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_data(upd_data),
    .wr_differs(wr_diff),
    .rd_idx(chg_idx), .rd_data(chg_data)
  );

  cfw_flag_map #(.DEPTH(DEPTH), .IDXW(IDXW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_en(upd_valid && wr_diff), .set_idx(upd_idx),
    .clr_en(take), .clr_idx(chg_idx),
    .flags(dirty)
  );

  cfw_lowest_first #(.N(DEPTH), .IDXW(IDXW)) u_pick (
    .req(dirty), .any(chg_valid), .sel(chg_idx)
  );
endmodule

// File: rtl/cfw_checker.sv
module cfw_checker #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned IDXW  = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic [IDXW-1:0]  upd_idx,
  input logic             wr_diff,
  input logic [DEPTH-1:0] dirty,
  input logic             chg_valid,
  input logic             chg_ready,
  input logic [IDXW-1:0]  chg_idx
);
  logic [DEPTH-1:0] below;
  logic             take, same_rewrite;
  assign below        = (DEPTH'(1) << chg_idx) - DEPTH'(1);
  assign take         = chg_valid && chg_ready;
  assign same_rewrite = upd_valid && wr_diff && (upd_idx == chg_idx);

  p_diff_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && wr_diff |=> dirty[$past(upd_idx)]);

  p_equal_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && wr_diff) && !take |=> $stable(dirty));

  p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> dirty[chg_idx] && ((dirty & below) == '0));

  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid && !chg_ready |=> chg_valid);

  p_clear_on_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !same_rewrite |=> !dirty[$past(chg_idx)]);

  p_rewrite_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && same_rewrite |=> dirty[$past(chg_idx)]);
endmodule

bind chg_fwd_table cfw_checker #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
  .wr_diff(wr_diff), .dirty(dirty), .chg_valid(chg_valid),
  .chg_ready(chg_ready), .chg_idx(chg_idx)
);

// File: tb/chg_fwd_table_bench.sv
`timescale 1ns/1ps
module chg_fwd_table_bench;
  localparam int N = 512;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic [8:0]  upd_idx = '0;
  logic [63:0] upd_data = '0;
  logic        chg_ready = 1'b0;
  logic        chg_valid;
  logic [8:0]  chg_idx;
  logic [63:0] chg_data;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  logic [63:0] m_word [N];
  bit          m_flag [N];

  always #5 clk = ~clk;

  chg_fwd_table u_chg_fwd_table (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_data(upd_data), .chg_valid(chg_valid), .chg_ready(chg_ready),
    .chg_idx(chg_idx), .chg_data(chg_data)
  );

  function automatic int m_first();
    for (int i = 0; i < N; i++) if (m_flag[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs against the model (inputs already driven, settled)
  task automatic compare(input string tag);
    int f;
    f = m_first();
    chk({tag, " R6 valid"}, 64'(chg_valid), 64'(f >= 0));
    if (f >= 0) begin
      chk({tag, " R5 index"}, 64'(chg_idx), 64'(f));
      chk({tag, " R4 data"}, chg_data, m_word[f]);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic step(input string tag, input bit wv, input int wi,
                      input logic [63:0] wd, input bit rdy);
    int f;
    bit accept;
    @(negedge clk);
    upd_valid = wv; upd_idx = 9'(wi); upd_data = wd; chg_ready = rdy;
    #1;
    compare(tag);
    f = m_first();
    accept = (f >= 0) && rdy;
    @(posedge clk);
    if (accept) m_flag[f] = 1'b0;
    if (wv && (m_word[wi] != wd)) begin
      m_word[wi] = wd;
      m_flag[wi] = 1'b1;
    end
  endtask

  task automatic idle(input string tag, input int n, input bit rdy);
    for (int k = 0; k < n; k++) step(tag, 1'b0, 0, 64'd0, rdy);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_word[i] = '0; m_flag[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    compare("R1 reset");
    // R1: zero write to fresh entry is not a change
    step("R1 zero", 1'b1, 5, 64'd0, 1'b0);
    idle("R1 zero after", 2, 1'b0);
    // R2: nonzero write flags and is offered
    step("R2 set", 1'b1, 7, 64'hDEAD_BEEF_0000_0001, 1'b0);
    idle("R2 offer", 2, 1'b0);
    // R3: equal write does nothing
    step("R3 equal", 1'b1, 7, 64'hDEAD_BEEF_0000_0001, 1'b0);
    idle("R3 after", 1, 1'b0);
    // R4: rewrites before drain -> forwarded once with latest
    step("R4 rw1", 1'b1, 7, 64'h1111, 1'b0);
    step("R4 rw2", 1'b1, 7, 64'h2222, 1'b0);
    idle("R4 drain", 3, 1'b1);
    // R5: lowest-first ordering
    step("R5 w300", 1'b1, 300, 64'h300, 1'b0);
    step("R5 w10", 1'b1, 10, 64'h10, 1'b0);
    step("R5 w511", 1'b1, 511, 64'h511, 1'b0);
    step("R5 w0", 1'b1, 0, 64'hABC, 1'b0);
    // R6: stalled output holds
    idle("R6 stall", 4, 1'b0);
    idle("R5 drain", 6, 1'b1);
    // R7: accept and same-index differing rewrite on the same edge
    step("R7 w20", 1'b1, 20, 64'h77, 1'b0);
    step("R7 take+rw", 1'b1, 20, 64'h88, 1'b1);
    idle("R7 later", 3, 1'b1);
    // R8: a write every cycle with random back-pressure
    for (int k = 0; k < 3000; k++) begin
      int wi;
      logic [63:0] wd;
      wi = (k % 3 == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 511));
      wd = 64'($urandom_range(0, 3));
      step("R8 stream", 1'b1, wi, wd, 1'($urandom_range(0, 1)));
    end
    idle("R8 final drain", 600, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule